// File: doc/BRIEF.md
# I2C Bus Clock and Data-Phase Timer

This block turns a fast core clock into the SCL waveform of an I2C master and marks, with single-cycle strobes, the moments at which the transfer engine should put the next bit on SDA and take the incoming bit from SDA. A 16-bit divider sets the SCL period in core clocks. SCL is low for the first half of each period and released (high) for the second half. Two delays, packed into one 32-bit word, place the drive strobe after each SCL fall and the sample strobe after each SCL rise.

The transfer engine raises a run level to start clocking and drops it to stop. The block always finishes the current period before going idle with SCL released. The block also watches the real SCL line. If a target holds SCL low while the block is releasing it, the phase counter freezes. If the hold lasts longer than a programmed number of SCL periods, a one-cycle timeout pulse is raised.

Top module: `i2c_sclk_gen`

## Requirements
- R1: With a divider value D of at least 2, one SCL period lasts D rounded down to even core clocks. SCL is low for the first half of the period and high for the second half, and the low half starts on the cycle after run is first seen high.
- R2: Bit 0 of the divider is ignored, so D=9 yields the same period as D=8.
- R3: A divider that rounds to zero (values 0 and 1) gives a period of 32768 core clocks.
- R4: The drive strobe is high for one cycle, F core clocks after the cycle in which SCL went low. F is the fall delay, held in bits 31:16 of the delay word.
- R5: The sample strobe is high for one cycle, R core clocks after the cycle in which SCL went high. R is the rise delay, held in bits 15:0 of the delay word.
- R6: Each delay is clamped to half the effective period.
- R7: A delay field of 0 acts as 1 core clock.
- R8: When run drops, the current period completes. After that SCL stays high and no drive strobe occurs.
- R9: While SCL is released but the line reads low, the phase counter holds, SCL stays released and no sample strobe is issued. After release, the sample strobe follows R core clocks later.
- R10: If the line is held low while released for L full SCL periods (L = stretch limit, nonzero), exactly one timeout pulse is issued, on the cycle after the L-th period ends. L=0 disables the timeout.
- R11: During and right after reset, SCL is high and all strobes and the timeout are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Clock SCL while high; finish the period and idle when low |
| div_i | input | 16 | SCL period in core clocks (bit 0 ignored) |
| dly_i | input | 32 | Fall delay in 31:16, rise delay in 15:0 |
| stretch_lim_i | input | 16 | Stretch timeout in SCL periods, 0 disables |
| scl_in_i | input | 1 | Sensed SCL line level |
| scl_o | output | 1 | SCL level driven (1 = released) |
| drive_stb_o | output | 1 | Put next bit on SDA |
| sample_stb_o | output | 1 | Sample SDA |
| timeout_o | output | 1 | Clock-stretch timeout pulse |

## Verification
The bench measures, from the SCL falling edge, the cycle offsets of the rise, the drive strobe, the sample strobe and the next fall. It does this for an odd divider, where keeping bit 0 would stretch the period by one. It also covers the zero divider, where a design without the substitution would stall or spin. Delays of zero and oversized delays are tried; a missing floor or clamp would shift the strobes or lose them. Stretch runs check that the timeout fires on exactly the expected cycle, only once, and never when the limit is zero. A run drop in mid-period checks that the period is finished and SCL is left released.

// File: rtl/i2c_sclk_pkg.sv
package i2c_sclk_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } scl_phase_e;

  localparam int N_DELAYS = 2;
  localparam int DLY_FALL = 0;
  localparam int DLY_RISE = 1;
endpackage

// File: rtl/i2c_sclk_cfg.sv
module i2c_sclk_cfg
  import i2c_sclk_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  input  logic [DIV_W-1:0] fall_i,
  input  logic [DIV_W-1:0] rise_i,
  output logic [DIV_W-1:0] half_o,
  output logic [DIV_W-1:0] fdly_o,
  output logic [DIV_W-1:0] rdly_o
);
  localparam logic [DIV_W-1:0] ZERO_PERIOD = {1'b1, {(DIV_W-1){1'b0}}};
  localparam logic [DIV_W-1:0] ONE         = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0] even_div, period, half;
  logic [N_DELAYS-1:0][DIV_W-1:0] raw_dly, clamp_dly;

  always_comb begin
    even_div = {div_i[DIV_W-1:1], 1'b0};
    period   = (even_div == '0) ? ZERO_PERIOD : even_div;
    half     = period >> 1;
  end

  assign raw_dly[DLY_FALL] = fall_i;
  assign raw_dly[DLY_RISE] = rise_i;

  for (genvar g = 0; g < N_DELAYS; g++) begin : g_clamp
    logic [DIV_W-1:0] floored;
    always_comb begin
      floored      = (raw_dly[g] == '0) ? ONE : raw_dly[g];
      clamp_dly[g] = (floored > half) ? half : floored;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_o <= ZERO_PERIOD >> 1;
      fdly_o <= ONE;
      rdly_o <= ONE;
    end else begin
      half_o <= half;
      fdly_o <= clamp_dly[DLY_FALL];
      rdly_o <= clamp_dly[DLY_RISE];
    end
  end

  assert_delay_bounds_R6: assert property (@(posedge clk) disable iff (rst)
    (fdly_o >= ONE) && (fdly_o <= half_o) && (rdly_o >= ONE) && (rdly_o <= half_o))
    else $error("delay outside 1..half");
endmodule

// File: rtl/i2c_sclk_phase.sv
module i2c_sclk_phase
  import i2c_sclk_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             scl_in_i,
  input  logic [DIV_W-1:0] half_i,
  input  logic [DIV_W-1:0] fdly_i,
  input  logic [DIV_W-1:0] rdly_i,
  output logic             scl_o,
  output logic             busy_o,
  output logic             drive_o,
  output logic             sample_o
);
  scl_phase_e       ph_q;
  logic             busy_q;
  logic [DIV_W-1:0] hc_q;
  logic             stall, last;

  assign stall  = busy_q && (ph_q == PH_HIGH) && !scl_in_i;
  assign last   = hc_q >= (half_i - 1'b1);
  assign scl_o  = (ph_q == PH_HIGH);
  assign busy_o = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      ph_q     <= PH_HIGH;
      hc_q     <= '0;
      drive_o  <= 1'b0;
      sample_o <= 1'b0;
    end else begin
      drive_o  <= 1'b0;
      sample_o <= 1'b0;
      if (!busy_q) begin
        if (run_i) begin
          busy_q <= 1'b1;
          ph_q   <= PH_LOW;
          hc_q   <= '0;
        end
      end else if (!stall) begin
        if (ph_q == PH_LOW) begin
          drive_o <= (hc_q == (fdly_i - 1'b1));
          if (last) begin
            ph_q <= PH_HIGH;
            hc_q <= '0;
          end else begin
            hc_q <= hc_q + 1'b1;
          end
        end else begin
          sample_o <= (hc_q == (rdly_i - 1'b1));
          if (last) begin
            hc_q <= '0;
            if (run_i) ph_q <= PH_LOW;
            else       busy_q <= 1'b0;
          end else begin
            hc_q <= hc_q + 1'b1;
          end
        end
      end
    end
  end

  assert_idle_released_R8: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> scl_o)
    else $error("SCL low while idle");

  assert_stall_freeze_R9: assert property (@(posedge clk) disable iff (rst)
    stall |=> ($stable(hc_q) && scl_o && !sample_o))
    else $error("phase moved during stretch");

  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(drive_o && sample_o))
    else $error("drive and sample strobes together");
endmodule

// File: rtl/i2c_sclk_stretch_mon.sv
module i2c_sclk_stretch_mon #(
  parameter int DIV_W = 16,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy_i,
  input  logic             scl_drv_i,
  input  logic             scl_in_i,
  input  logic [DIV_W-1:0] half_i,
  input  logic [TO_W-1:0]  limit_i,
  output logic             timeout_o
);
  logic [DIV_W-1:0] clk_cnt;
  logic [TO_W-1:0]  per_cnt;
  logic [DIV_W-1:0] period_m1;
  logic             stretched;

  assign period_m1 = {half_i[DIV_W-2:0], 1'b0} - 1'b1;
  assign stretched = busy_i && scl_drv_i && !scl_in_i;

  always_ff @(posedge clk) begin
    if (rst || !stretched) begin
      clk_cnt   <= '0;
      per_cnt   <= '0;
      timeout_o <= 1'b0;
    end else begin
      timeout_o <= 1'b0;
      if ((limit_i != '0) && (per_cnt < limit_i)) begin
        if (clk_cnt >= period_m1) begin
          clk_cnt <= '0;
          per_cnt <= per_cnt + 1'b1;
          if ((per_cnt + 1'b1) == limit_i) timeout_o <= 1'b1;
        end else begin
          clk_cnt <= clk_cnt + 1'b1;
        end
      end
    end
  end

  assert_timeout_single_R10: assert property (@(posedge clk) disable iff (rst)
    timeout_o |=> !timeout_o)
    else $error("timeout longer than one cycle");

  assert_timeout_cause_R10: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> ($past(stretched) && (limit_i != '0)))
    else $error("timeout without stretch");
endmodule

// File: rtl/i2c_sclk_gen.sv
module i2c_sclk_gen #(
  parameter int DIV_W = 16,
  parameter int TO_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic [2*DIV_W-1:0] dly_i,
  input  logic [TO_W-1:0]    stretch_lim_i,
  input  logic               scl_in_i,
  output logic               scl_o,
  output logic               drive_stb_o,
  output logic               sample_stb_o,
  output logic               timeout_o
);
  logic [DIV_W-1:0] half, fdly, rdly;
  logic             busy;

  i2c_sclk_cfg #(.DIV_W(DIV_W)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .div_i  (div_i),
    .fall_i (dly_i[2*DIV_W-1:DIV_W]),
    .rise_i (dly_i[DIV_W-1:0]),
    .half_o (half),
    .fdly_o (fdly),
    .rdly_o (rdly)
  );

  i2c_sclk_phase #(.DIV_W(DIV_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .run_i    (run_i),
    .scl_in_i (scl_in_i),
    .half_i   (half),
    .fdly_i   (fdly),
    .rdly_i   (rdly),
    .scl_o    (scl_o),
    .busy_o   (busy),
    .drive_o  (drive_stb_o),
    .sample_o (sample_stb_o)
  );

  i2c_sclk_stretch_mon #(.DIV_W(DIV_W), .TO_W(TO_W)) u_mon (
    .clk       (clk),
    .rst       (rst),
    .busy_i    (busy),
    .scl_drv_i (scl_o),
    .scl_in_i  (scl_in_i),
    .half_i    (half),
    .limit_i   (stretch_lim_i),
    .timeout_o (timeout_o)
  );
endmodule

// File: tb/tb_i2c_sclk_gen.sv
module tb_i2c_sclk_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic [15:0] div = 16'd8;
  logic [31:0] dly = 32'h0001_0001;
  logic [15:0] lim = 16'd0;
  logic        hold = 1'b0;
  logic        scl_in, scl, drv, smp, tmo;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;
  assign scl_in = scl & ~hold;

  i2c_sclk_gen dut (
    .clk(clk), .rst(rst), .run_i(run), .div_i(div), .dly_i(dly),
    .stretch_lim_i(lim), .scl_in_i(scl_in), .scl_o(scl),
    .drive_stb_o(drv), .sample_stb_o(smp), .timeout_o(tmo)
  );

  task automatic chk(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic setup(input logic [15:0] d, input logic [31:0] dl, input logic [15:0] l);
    @(negedge clk);
    div = d; dly = dl; lim = l;
    repeat (3) @(negedge clk);
  endtask

  task automatic stop_run(input int h);
    int hi_run = 0;
    run = 1'b0;
    for (int i = 0; i < 70000 && hi_run < 2*h + 2; i++) begin
      @(negedge clk);
      hi_run = scl ? hi_run + 1 : 0;
    end
  endtask

  task automatic t_period(input logic [15:0] d, input logic [31:0] dl,
                          input int h, input int fd, input int rd, input string req);
    int k, t_rise, t_drv, t_smp, t_per;
    t_rise = -1; t_drv = -1; t_smp = -1; t_per = -1;
    setup(d, dl, 16'd0);
    run = 1'b1;
    @(negedge clk);
    k = 0;
    for (int i = 0; i < 70000; i++) begin
      @(negedge clk);
      k++;
      if (drv && t_drv < 0) t_drv = k;
      if (smp && t_smp < 0) t_smp = k;
      if (scl && t_rise < 0) t_rise = k;
      if (!scl && t_rise >= 0) begin t_per = k; break; end
    end
    chk(t_rise, h, req, "rise offset");
    chk(t_per, 2*h, req, "period");
    chk(t_drv, fd, req, "drive offset");
    chk(t_smp, h + rd, req, "sample offset");
    stop_run(h);
  endtask

  task automatic t_reset;
    chk(scl, 1, "R11", "scl in reset");
    chk(drv, 0, "R11", "drive in reset");
    chk(smp, 0, "R11", "sample in reset");
    chk(tmo, 0, "R11", "timeout in reset");
  endtask

  task automatic t_stretch(input logic [15:0] l, input int exp_first, input int exp_cnt);
    int first = -1, cnt = 0, low_seen = 0, smp_seen = 0, rel_smp = -1;
    setup(16'd8, 32'h0001_0002, l);
    run = 1'b1;
    for (int i = 0; i < 100 && !scl; i++) @(negedge clk);
    for (int i = 0; i < 100 && scl; i++) @(negedge clk);
    for (int i = 0; i < 100 && !scl; i++) @(negedge clk);
    hold = 1'b1;
    for (int j = 1; j <= 40; j++) begin
      @(negedge clk);
      if (tmo) begin cnt++; if (first < 0) first = j; end
      if (!scl) low_seen++;
      if (smp) smp_seen++;
    end
    hold = 1'b0;
    for (int j = 1; j <= 4; j++) begin
      @(negedge clk);
      if (smp && rel_smp < 0) rel_smp = j;
    end
    chk(cnt, exp_cnt, "R10", "timeout pulses");
    if (exp_cnt > 0) chk(first, exp_first, "R10", "timeout cycle");
    chk(low_seen, 0, "R9", "scl driven low while stretched");
    chk(smp_seen, 0, "R9", "sample during stretch");
    chk(rel_smp, 2, "R9", "sample offset after release");
    stop_run(4);
  endtask

  task automatic t_idle;
    int late_drv = 0, late_low = 0;
    setup(16'd8, 32'h0001_0001, 16'd0);
    run = 1'b1;
    @(negedge clk);
    @(negedge clk);
    run = 1'b0;
    for (int k = 2; k <= 30; k++) begin
      @(negedge clk);
      if (drv) late_drv++;
      if (k >= 4 && !scl) late_low++;
    end
    chk(late_low, 0, "R8", "scl low after run dropped");
    chk(late_drv, 0, "R8", "drive strobe after run dropped");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_period(16'd8,  32'h0001_0002, 4, 1, 2, "R1 R4 R5");
    t_period(16'd9,  32'h0003_0001, 4, 3, 1, "R2");
    t_period(16'd10, 32'h0009_0064, 5, 5, 5, "R6");
    t_period(16'd2,  32'h0000_0000, 1, 1, 1, "R7");
    t_period(16'd0,  32'h0000_0000, 16384, 1, 1, "R3 R7");
    t_stretch(16'd3, 24, 1);
    t_stretch(16'd0, 0, 0);
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule